// File: doc/BRIEF.md
# Pixel Hit Time Digitizer

This block holds the digital control and arithmetic that measure when a particle hit one pixel. It runs from the master clock and observes a time-stamp bus that advances once per master cycle, a hit strobe from the pixel's discriminator, and a strobe from the ramp comparator that reports the end of the discharge. On a hit it stores the bus value as the coarse time. It then steps the analog ramp through three phases: charge, a one-cycle settle, and discharge. The hit-to-edge interval, stretched 128 times by the slow discharge, is measured by subtracting the bus value taken at the start of the discharge from the one taken at its end.

The fine code is the hit's phase within a two-master-cycle reference period. Its top bit therefore repeats the information in the coarse LSB. When the two disagree, the coarse value was sampled across a bus transition. The block moves the coarse value by one count toward the side the fine code indicates. It then issues one merged word, with the corrected coarse count above the lower fine bits, together with a one-cycle valid pulse. If the discharge never ends, the measurement is abandoned and an error word is issued.

Top module: `hit_time_digitizer`

## Requirements
- R1: While `busy` is low, a high `hitStrobe` at a clock edge stores `timeStamp` as the coarse time. In the following cycle both `busy` and `chargeEn` are high.
- R2: After an accepted hit, `chargeEn` is high for exactly one cycle and then `holdEn` for exactly one cycle. `dischargeEn` follows until the discharge ends. At most one of the three is high in any cycle.
- R3: The start stamp is `timeStamp` at the edge that enters discharge. The end stamp is `timeStamp` at the edge where `dischDone` is first sampled high during discharge. The fine phase is the FINE_W-bit value of (start − end) modulo 2^FINE_W, so a discharge of 256 cycles gives phase 0.
- R4: Alignment uses the phase MSB (bit 7) and bit 6. If the coarse LSB equals bit 7, the coarse value is used as stored. Otherwise the coarse value gets +1 when bit 6 is 0 and −1 when bit 6 is 1. The result wraps modulo 2^TS_W.
- R5: A good result word is {1'b0, corrected coarse[11:0], phase[6:0]}, 20 bits with the default widths. Bit 19 is the error flag.
- R6: `outValid` rises in the second cycle after the edge that samples `dischDone` and lasts one cycle. `busy` is low in that cycle.
- R7: A `hitStrobe` that arrives while `busy` is high is ignored. It changes neither the result in progress nor starts a new measurement.
- R8: If `dischDone` has not been sampled within TIMEOUT (256) discharge cycles, the measurement is aborted. `outValid` is raised in the next cycle with the word {1'b1, stored coarse, 7'b0}, and `dischargeEn` is low.
- R9: After reset, `chargeEn`, `holdEn`, `dischargeEn`, `busy` and `outValid` are low and `outWord` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeStamp | input | TS_W (12) | Global time-stamp bus, synchronous to clk |
| hitStrobe | input | 1 | Discriminator hit indication, sampled at clock edges |
| dischDone | input | 1 | Ramp comparator: discharge finished |
| chargeEn | output | 1 | Ramp charge window |
| holdEn | output | 1 | Ramp stopped, settle cycle |
| dischargeEn | output | 1 | Slow discharge running |
| busy | output | 1 | Measurement in progress |
| outValid | output | 1 | One-cycle strobe for outWord |
| outWord | output | TS_W+FINE_W (20) | {error, corrected coarse, phase low bits} |

## Verification
Phases and coarse values are drawn at random, which exercises every combination of coarse parity and phase half, so aligned results can be told apart from corrections in each direction. Directed cases pin the extremes. A phase of 0 requires a 256-cycle discharge and separates "done on the last allowed cycle" from a timeout. A phase of 255 gives a one-cycle discharge. Coarse values of 0 and 4095 with a mismatch show that the adjustment wraps. A run without a done strobe shows the abort word, and hits injected during charge, settle and discharge show that they neither disturb the result nor start a second measurement.

// File: rtl/htd_pkg.sv
package htd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHARGE,
    ST_SETTLE,
    ST_DISCH,
    ST_DONE
  } htdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCoarse;
    logic latchStart;
    logic latchEnd;
    logic emitResult;
    logic emitError;
  } htdStrobes_t;

endpackage

// File: rtl/htd_control.sv
module htd_control
  import htd_pkg::*;
#(
  parameter int TIMEOUT = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hitStrobe,
  input  logic        dischDone,
  output htdStrobes_t strobes,
  output logic        chargeEn,
  output logic        holdEn,
  output logic        dischargeEn,
  output logic        busy
);

  localparam int CNT_W = $clog2(TIMEOUT);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT - 1);

  htdState_e state, nextState;
  logic [CNT_W-1:0] dischCnt;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (hitStrobe) begin
          strobes.latchCoarse = 1'b1;
          nextState = ST_CHARGE;
        end
      end
      ST_CHARGE: nextState = ST_SETTLE;
      ST_SETTLE: begin
        strobes.latchStart = 1'b1;
        nextState = ST_DISCH;
      end
      ST_DISCH: begin
        if (dischDone) begin
          strobes.latchEnd = 1'b1;
          nextState = ST_DONE;
        end else if (dischCnt == LAST_CNT) begin
          strobes.emitError = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_DONE: begin
        strobes.emitResult = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dischCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_DISCH) dischCnt <= dischCnt + 1'b1;
      else                   dischCnt <= '0;
    end
  end

  assign chargeEn    = (state == ST_CHARGE);
  assign holdEn      = (state == ST_SETTLE);
  assign dischargeEn = (state == ST_DISCH);
  assign busy        = (state != ST_IDLE);

endmodule

// File: rtl/htd_datapath.sv
module htd_datapath
  import htd_pkg::*;
#(
  parameter int TS_W   = 12,
  parameter int FINE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [TS_W-1:0]          timeStamp,
  input  htdStrobes_t              strobes,
  output logic                     outValid,
  output logic [TS_W+FINE_W-1:0]   outWord
);

  localparam int WORD_W = TS_W + FINE_W;

  logic [TS_W-1:0]   coarseReg, startReg, endReg;
  logic [TS_W-1:0]   stretched;
  logic [FINE_W-1:0] phase;
  logic              mismatch;
  logic [TS_W-1:0]   coarseFixed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coarseReg <= '0;
      startReg  <= '0;
      endReg    <= '0;
    end else begin
      if (strobes.latchCoarse) coarseReg <= timeStamp;
      if (strobes.latchStart)  startReg  <= timeStamp;
      if (strobes.latchEnd)    endReg    <= timeStamp;
    end
  end

  // discharge length in master cycles, turned into hit phase
  assign stretched   = endReg - startReg;
  assign phase       = FINE_W'(0) - stretched[FINE_W-1:0];
  assign mismatch    = coarseReg[0] ^ phase[FINE_W-1];
  assign coarseFixed = !mismatch          ? coarseReg :
                       phase[FINE_W-2]    ? coarseReg - TS_W'(1) :
                                            coarseReg + TS_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWord  <= '0;
    end else begin
      outValid <= strobes.emitResult | strobes.emitError;
      if (strobes.emitResult)
        outWord <= {1'b0, coarseFixed, phase[FINE_W-2:0]};
      else if (strobes.emitError)
        outWord <= {1'b1, coarseReg, {(FINE_W-1){1'b0}}};
    end
  end

  logic unusedWidth;
  assign unusedWidth = (WORD_W == 0);

endmodule

// File: rtl/hit_time_digitizer.sv
module hit_time_digitizer
  import htd_pkg::*;
#(
  parameter int TS_W    = 12,
  parameter int FINE_W  = 8,
  parameter int TIMEOUT = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TS_W-1:0]        timeStamp,
  input  logic                   hitStrobe,
  input  logic                   dischDone,
  output logic                   chargeEn,
  output logic                   holdEn,
  output logic                   dischargeEn,
  output logic                   busy,
  output logic                   outValid,
  output logic [TS_W+FINE_W-1:0] outWord
);

  htdStrobes_t strobes;

  htd_control #(.TIMEOUT(TIMEOUT)) ctrl (
    .clk(clk), .rstN(rstN), .hitStrobe(hitStrobe), .dischDone(dischDone),
    .strobes(strobes), .chargeEn(chargeEn), .holdEn(holdEn),
    .dischargeEn(dischargeEn), .busy(busy)
  );

  htd_datapath #(.TS_W(TS_W), .FINE_W(FINE_W)) dp (
    .clk(clk), .rstN(rstN), .timeStamp(timeStamp), .strobes(strobes),
    .outValid(outValid), .outWord(outWord)
  );

endmodule

// File: rtl/htd_checker.sv
module htd_checker #(
  parameter int FINE_W  = 8,
  parameter int WORD_W  = 20,
  parameter int TIMEOUT = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              hitStrobe,
  input logic              chargeEn,
  input logic              holdEn,
  input logic              dischargeEn,
  input logic              busy,
  input logic              outValid,
  input logic [WORD_W-1:0] outWord
);

  localparam int RUN_W = $clog2(TIMEOUT) + 2;

  logic [RUN_W-1:0] runLen;
  always_ff @(posedge clk) begin
    if (!rstN)            runLen <= '0;
    else if (dischargeEn) runLen <= runLen + 1'b1;
    else                  runLen <= '0;
  end

  assert_hit_starts_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && hitStrobe) |=> (busy && chargeEn));

  assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({chargeEn, holdEn, dischargeEn}));

  assert_charge_then_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    chargeEn |=> holdEn);

  assert_hold_then_disch_R2: assert property (@(posedge clk) disable iff (!rstN)
    holdEn |=> dischargeEn);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  assert_valid_not_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !busy);

  assert_busy_ends_with_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> outValid);

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chargeEn) |-> $past(!busy));

  assert_disch_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    dischargeEn |-> (runLen < RUN_W'(TIMEOUT)));

  assert_error_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outWord[WORD_W-1]) |-> (outWord[FINE_W-2:0] == '0));

endmodule

bind hit_time_digitizer htd_checker #(
  .FINE_W(FINE_W), .WORD_W(TS_W + FINE_W), .TIMEOUT(TIMEOUT)
) chk (
  .clk(clk), .rstN(rstN), .hitStrobe(hitStrobe), .chargeEn(chargeEn),
  .holdEn(holdEn), .dischargeEn(dischargeEn), .busy(busy),
  .outValid(outValid), .outWord(outWord)
);

// File: tb/hit_time_digitizer_test.sv
module hit_time_digitizer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] timeStamp = '0;
  logic        hitStrobe = 1'b0;
  logic        dischDone = 1'b0;
  logic        chargeEn, holdEn, dischargeEn, busy, outValid;
  logic [19:0] outWord;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;              // 50 MHz
  always @(posedge clk) timeStamp <= timeStamp + 12'd1;

  hit_time_digitizer uut (
    .clk(clk), .rstN(rstN), .timeStamp(timeStamp), .hitStrobe(hitStrobe),
    .dischDone(dischDone), .chargeEn(chargeEn), .holdEn(holdEn),
    .dischargeEn(dischargeEn), .busy(busy), .outValid(outValid),
    .outWord(outWord)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] fixCoarse(input logic [11:0] c, input logic [7:0] p);
    if (c[0] == p[7]) return c;
    return p[6] ? c - 12'd1 : c + 12'd1;
  endfunction

  function automatic logic [19:0] goodWord(input logic [11:0] c, input logic [7:0] p);
    return {1'b0, fixCoarse(c, p), p[6:0]};
  endfunction

  // one measurement; extraHit injects hits during charge, settle, discharge
  task automatic measure(input logic [11:0] c, input logic [7:0] p,
                         input bit noDone, input bit extraHit);
    int dischLen;
    dischLen = (p == 8'd0) ? 256 : 256 - int'(p);
    @(negedge clk); timeStamp = c; hitStrobe = 1'b1;
    @(negedge clk); hitStrobe = extraHit;
    check(chargeEn && busy, "R1 charge+busy after hit", {chargeEn, busy}, 2'b11);
    @(negedge clk); hitStrobe = extraHit;
    check(holdEn && !chargeEn, "R2 settle cycle", {chargeEn, holdEn}, 2'b01);
    @(negedge clk); hitStrobe = 1'b0;
    check(dischargeEn && !holdEn, "R2 discharge starts", {holdEn, dischargeEn}, 2'b01);
    if (noDone) begin
      if (extraHit) hitStrobe = 1'b1;
      repeat (255) @(negedge clk);
      hitStrobe = 1'b0;
      check(dischargeEn && !outValid, "R8 still discharging at cycle 255",
            {dischargeEn, outValid}, 2'b10);
      @(negedge clk);
      check(outValid && !dischargeEn, "R8 abort strobe", {outValid, dischargeEn}, 2'b10);
      check(outWord == {1'b1, c, 7'd0}, "R8 error word", outWord, {1'b1, c, 7'd0});
    end else begin
      if (extraHit) hitStrobe = 1'b1;
      repeat (dischLen - 1) @(negedge clk);
      hitStrobe = 1'b0;
      dischDone = 1'b1;
      @(negedge clk); dischDone = 1'b0;
      check(!outValid && busy, "R6 no result one cycle after done",
            {outValid, busy}, 2'b01);
      @(negedge clk);
      check(outValid && !busy, "R6 valid with busy low", {outValid, busy}, 2'b10);
      check(outWord == goodWord(c, p), "R3 R4 R5 merged word", outWord, goodWord(c, p));
      @(negedge clk);
      check(!outValid, "R6 one-cycle pulse", outValid, 0);
    end
    if (extraHit) begin
      repeat (3) @(negedge clk);
      check(!busy && !chargeEn, "R7 ignored hit started nothing", {busy, chargeEn}, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check({chargeEn, holdEn, dischargeEn, busy, outValid} == 0 && outWord == 0,
          "R9 outputs in reset", {chargeEn, holdEn, dischargeEn, busy, outValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({chargeEn, holdEn, dischargeEn, busy, outValid} == 0 && outWord == 0,
          "R9 idle after reset", outWord, 0);

    // directed corners
    measure(12'h100, 8'h00, 1'b0, 1'b0);  // R3: 256-cycle discharge, last allowed
    measure(12'h101, 8'hFF, 1'b0, 1'b0);  // one-cycle discharge
    measure(12'h222, 8'h01, 1'b0, 1'b0);  // aligned, even coarse
    measure(12'h222, 8'h81, 1'b0, 1'b0);  // R4 mismatch early half: +1
    measure(12'h333, 8'h7F, 1'b0, 1'b0);  // R4 mismatch late half: -1
    measure(12'h000, 8'hC0, 1'b0, 1'b0);  // R4 wrap down to FFF
    measure(12'hFFF, 8'h10, 1'b0, 1'b0);  // R4 wrap up to 000
    measure(12'h4A5, 8'h00, 1'b1, 1'b0);  // R8 timeout
    measure(12'h555, 8'h40, 1'b0, 1'b1);  // R7 hits while busy
    measure(12'h6A6, 8'h00, 1'b1, 1'b1);  // R7 + R8

    // random measurements
    for (int i = 0; i < 40; i++) begin
      logic [11:0] c;
      logic [7:0]  p;
      c = 12'($urandom());
      p = 8'($urandom());
      measure(c, p, 1'b0, ($urandom() % 5) == 0);
      repeat ($urandom() % 4) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule